// File: doc/BRIEF.md
# Reservation-based conditional store unit

This unit carries out the load-reserved and store-conditional pair of atomic memory operations for a single hardware thread, in both a 32-bit word form and a 64-bit doubleword form. The pipeline presents an operation as already-decoded fields together with the base address and the store operand. The unit checks the operation, talks to a single-ported memory through a request/response handshake, and then finishes with exactly one of two outcomes. Either it reports an exception with a cause and a fault value, or it writes a destination-register value and raises a completion pulse that lets the program counter move on.

The unit keeps one reservation, made of a valid flag and the index of a RAM granule. The index is the RAM-relative address divided by `GRAN_BYTES`. A load-reserved operation always drops the old reservation. If it passes its checks, it reserves the granule of its address. A store-conditional operation writes memory only when a live reservation covers its address. It returns 0 on success and 1 on failure, and it always uses up the reservation. A snoop port carries write addresses from other agents, and a snoop that lands in the reserved granule kills the reservation. The ordering bits of the instruction play no part here.

Top module: `lrsc_unit`

## Requirements
- R1: An operation is accepted when `op_valid` is high while the unit is idle. `op_funct5` = 00010 means load-reserved and 00011 means store-conditional. `op_funct3` = 010 means word and 011 means doubleword. Any other pair raises exception cause 2 with fault value 0, makes no memory request, and leaves the reservation as it was.
- R2: A load-reserved operation whose `op_rs2_idx` is not zero is illegal: cause 2, fault value 0, reservation unchanged.
- R3: A word access needs address bits [1:0] = 0 and a doubleword access needs bits [2:0] = 0. A misaligned load-reserved raises cause 4. A misaligned store-conditional that holds a live reservation raises cause 6. In both cases the fault value is the address, and a faulting store-conditional keeps its reservation.
- R4: An address below `RAM_BASE`, or at or above `RAM_BASE + RAM_BYTES`, raises cause 5 for load-reserved and cause 7 for a store-conditional that holds a live reservation. The fault value is the address. Alignment is checked before range.
- R5: Every accepted legal load-reserved first clears the reservation, so one that faults leaves no reservation.
- R6: A load-reserved that passes its checks issues a read. The read has `mem_req_write` = 0, `mem_req_dword` equal to the form, and `mem_req_addr` equal to the address. A word read returns its data in `mem_rsp_rdata[31:0]`. The unit writes the response to rd, with the word form sign-extended from bit 31. It reserves granule (address − `RAM_BASE`) / `GRAN_BYTES`.
- R7: A store-conditional without a live reservation writes 1 to rd and makes no memory request. It raises no exception, whatever its address.
- R8: A store-conditional with a live reservation on a different granule writes 1 to rd, clears the reservation, and makes no memory request.
- R9: A store-conditional whose granule matches a live reservation clears the reservation and issues a write. The doubleword form carries the whole store operand. The word form carries the low 32 bits with bits [63:32] zero. rd receives 0 once the write is accepted.
- R10: A snoop whose address lies in RAM and in the reserved granule clears the reservation in that cycle. If the snoop arrives in the same cycle a store-conditional is accepted, the store fails. If the snoop arrives in the same cycle a load-reserved is accepted and hits that load's granule, no reservation is formed.
- R11: Each accepted operation produces exactly one single-cycle pulse. The pulse is either `exc_valid` or `done` with `rd_we`, never both. It appears in the cycle after the decision: after acceptance, after the response, or after the write handshake. All three pulses are low out of reset.
- R12: A memory request stays asserted with its address, size and data unchanged until `mem_req_ready` is sampled high, and no request is active out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present (taken when idle) |
| op_funct5 | input | 5 | Operation class field |
| op_funct3 | input | 3 | Access width field |
| op_rs2_idx | input | 5 | Second source register index field |
| op_addr | input | 64 | Effective address |
| op_wdata | input | 64 | Store operand |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_dword | output | 1 | 1 = 64-bit, 0 = 32-bit |
| mem_req_addr | output | 64 | Request address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Read data |
| snoop_valid | input | 1 | Another agent writes this cycle |
| snoop_addr | input | 64 | Address of that write |
| rd_we | output | 1 | Destination register write strobe |
| rd_wdata | output | 64 | Destination register value |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 4 | Exception cause code |
| exc_tval | output | 64 | Exception fault value |
| done | output | 1 | Completion pulse (advance PC) |

## Verification
A foreign-agent snoop and a store-conditional acceptance can land in the same cycle. The same is true of a snoop and a load-reserved acceptance. The bench provokes both on purpose, and also at random, by raising `snoop_valid` in the very cycle that carries `op_valid`, sometimes aimed at the reserved granule and sometimes elsewhere. The expected result is judged from the reservation model in the bench. A snoop that hits the live granule must turn the store into a failure that writes 1 and makes no write request. A snoop that hits a new load's granule must leave the following store without a reservation.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam int DATA_W  = 64;
    localparam int CAUSE_W = 4;

    localparam logic [4:0] F5_LOAD_RES  = 5'b00010;
    localparam logic [4:0] F5_STORE_CND = 5'b00011;
    localparam logic [2:0] F3_WORD      = 3'b010;
    localparam logic [2:0] F3_DWORD     = 3'b011;

    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_MISAL = 4'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT = 4'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_MISAL = 4'd6;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT = 4'd7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ
    } state_e;

    typedef enum logic [1:0] {
        ACT_EXC,
        ACT_READ,
        ACT_FAIL,
        ACT_WRITE
    } action_e;

endpackage

// File: rtl/lrsc_addr_map.sv
module lrsc_addr_map
    import lrsc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RAM_BASE   = 64'h0000_0000_8000_0000,
    parameter int unsigned       RAM_BYTES  = 4096,
    parameter int unsigned       GRAN_BYTES = 64,
    localparam int RAM_AW   = $clog2(RAM_BYTES),
    localparam int GRAN_LSB = $clog2(GRAN_BYTES),
    localparam int IDX_W    = RAM_AW - GRAN_LSB
) (
    input  logic [DATA_W-1:0] addr,
    output logic              in_ram,
    output logic [IDX_W-1:0]  gran
);

    logic [DATA_W-1:0] rel;

    always_comb begin
        rel    = addr - RAM_BASE;
        in_ram = (addr >= RAM_BASE) && (rel < DATA_W'(RAM_BYTES));
        gran   = rel[RAM_AW-1:GRAN_LSB];
    end

endmodule

// File: rtl/lrsc_decode.sv
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic [4:0]         funct5,
    input  logic [2:0]         funct3,
    input  logic [4:0]         rs2_idx,
    input  logic [2:0]         addr_lo,
    input  logic               in_ram,
    input  logic               resv_live,
    input  logic               gran_match,
    output action_e            act,
    output logic [CAUSE_W-1:0] cause,
    output logic               tval_addr,
    output logic               is_dword,
    output logic               resv_clr,
    output logic               resv_set
);

    logic is_lr;
    logic is_sc;
    logic width_ok;
    logic misal;
    logic legal;

    always_comb begin
        is_lr    = (funct5 == F5_LOAD_RES);
        is_sc    = (funct5 == F5_STORE_CND);
        is_dword = (funct3 == F3_DWORD);
        width_ok = (funct3 == F3_WORD) || is_dword;
        misal    = is_dword ? (addr_lo != 3'b000) : (addr_lo[1:0] != 2'b00);
        legal    = width_ok && ((is_lr && (rs2_idx == 5'd0)) || is_sc);

        act       = ACT_EXC;
        cause     = CAUSE_ILLEGAL;
        tval_addr = 1'b0;
        resv_clr  = 1'b0;
        resv_set  = 1'b0;

        if (legal && is_lr) begin
            resv_clr  = 1'b1;
            tval_addr = 1'b1;
            if (misal) begin
                cause = CAUSE_LD_MISAL;
            end else if (!in_ram) begin
                cause = CAUSE_LD_FAULT;
            end else begin
                act      = ACT_READ;
                resv_set = 1'b1;
            end
        end else if (legal && is_sc) begin
            tval_addr = 1'b1;
            if (!resv_live) begin
                act      = ACT_FAIL;
                resv_clr = 1'b1;
            end else if (misal) begin
                cause = CAUSE_ST_MISAL;
            end else if (!in_ram) begin
                cause = CAUSE_ST_FAULT;
            end else if (!gran_match) begin
                act      = ACT_FAIL;
                resv_clr = 1'b1;
            end else begin
                act      = ACT_WRITE;
                resv_clr = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             set_i,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             snoop_hit,
    input  logic [IDX_W-1:0] snoop_idx,
    output logic             live_o,
    output logic [IDX_W-1:0] tag_o
);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] tag;
    } resv_t;

    resv_t cur_q;
    resv_t nxt_d;
    logic  kill_old;
    logic  kill_new;

    always_comb begin
        kill_old = snoop_hit && (snoop_idx == cur_q.tag);
        kill_new = snoop_hit && (snoop_idx == set_idx);
        live_o   = cur_q.valid && !kill_old;
        tag_o    = cur_q.tag;

        nxt_d       = cur_q;
        nxt_d.valid = live_o;
        if (clr_i) begin
            nxt_d.valid = 1'b0;
        end
        if (set_i) begin
            nxt_d.tag   = set_idx;
            nxt_d.valid = !kill_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit && (snoop_idx == cur_q.tag) && !set_i) |=> !cur_q.valid); // R10

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !cur_q.valid); // R5

    AST_SET_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (cur_q.tag == $past(set_idx))); // R6

endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RAM_BASE   = 64'h0000_0000_8000_0000,
    parameter int unsigned       RAM_BYTES  = 4096,
    parameter int unsigned       GRAN_BYTES = 64,
    localparam int IDX_W = $clog2(RAM_BYTES) - $clog2(GRAN_BYTES),
    localparam int HALF_W = DATA_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [4:0]         op_funct5,
    input  logic [2:0]         op_funct3,
    input  logic [4:0]         op_rs2_idx,
    input  logic [DATA_W-1:0]  op_addr,
    input  logic [DATA_W-1:0]  op_wdata,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic               mem_req_dword,
    output logic [DATA_W-1:0]  mem_req_addr,
    output logic [DATA_W-1:0]  mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [DATA_W-1:0]  mem_rsp_rdata,
    input  logic               snoop_valid,
    input  logic [DATA_W-1:0]  snoop_addr,
    output logic               rd_we,
    output logic [DATA_W-1:0]  rd_wdata,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [DATA_W-1:0]  exc_tval,
    output logic               done
);

    typedef struct packed {
        state_e              state;
        logic                rd_we;
        logic [DATA_W-1:0]   rd_wdata;
        logic                exc_valid;
        logic [CAUSE_W-1:0]  exc_cause;
        logic [DATA_W-1:0]   exc_tval;
        logic                done;
        logic                dword;
        logic [DATA_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } ctl_t;

    ctl_t ctl_q;
    ctl_t ctl_d;

    logic               op_in_ram;
    logic [IDX_W-1:0]   op_gran;
    logic               snp_in_ram;
    logic [IDX_W-1:0]   snp_gran;
    logic               snp_hit;
    logic               resv_live;
    logic [IDX_W-1:0]   resv_tag;
    action_e            dec_act;
    logic [CAUSE_W-1:0] dec_cause;
    logic               dec_tval_addr;
    logic               dec_dword;
    logic               dec_clr;
    logic               dec_set;
    logic               accept;

    lrsc_addr_map #(
        .RAM_BASE   (RAM_BASE),
        .RAM_BYTES  (RAM_BYTES),
        .GRAN_BYTES (GRAN_BYTES)
    ) u_op_map (
        .addr   (op_addr),
        .in_ram (op_in_ram),
        .gran   (op_gran)
    );

    lrsc_addr_map #(
        .RAM_BASE   (RAM_BASE),
        .RAM_BYTES  (RAM_BYTES),
        .GRAN_BYTES (GRAN_BYTES)
    ) u_snoop_map (
        .addr   (snoop_addr),
        .in_ram (snp_in_ram),
        .gran   (snp_gran)
    );

    assign snp_hit = snoop_valid && snp_in_ram;
    assign accept  = op_valid && (ctl_q.state == ST_IDLE);

    lrsc_decode u_decode (
        .funct5     (op_funct5),
        .funct3     (op_funct3),
        .rs2_idx    (op_rs2_idx),
        .addr_lo    (op_addr[2:0]),
        .in_ram     (op_in_ram),
        .resv_live  (resv_live),
        .gran_match (op_gran == resv_tag),
        .act        (dec_act),
        .cause      (dec_cause),
        .tval_addr  (dec_tval_addr),
        .is_dword   (dec_dword),
        .resv_clr   (dec_clr),
        .resv_set   (dec_set)
    );

    lrsc_resv #(
        .IDX_W (IDX_W)
    ) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept && dec_clr),
        .set_i     (accept && dec_set),
        .set_idx   (op_gran),
        .snoop_hit (snp_hit),
        .snoop_idx (snp_gran),
        .live_o    (resv_live),
        .tag_o     (resv_tag)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rd_we     = 1'b0;
        ctl_d.exc_valid = 1'b0;
        ctl_d.done      = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (op_valid) begin
                    ctl_d.addr  = op_addr;
                    ctl_d.dword = dec_dword;
                    ctl_d.wdata = dec_dword ? op_wdata
                                            : {{HALF_W{1'b0}}, op_wdata[HALF_W-1:0]};
                    unique case (dec_act)
                        ACT_EXC: begin
                            ctl_d.exc_valid = 1'b1;
                            ctl_d.exc_cause = dec_cause;
                            ctl_d.exc_tval  = dec_tval_addr ? op_addr : '0;
                        end
                        ACT_FAIL: begin
                            ctl_d.rd_we    = 1'b1;
                            ctl_d.rd_wdata = DATA_W'(1);
                            ctl_d.done     = 1'b1;
                        end
                        ACT_READ:  ctl_d.state = ST_RD_REQ;
                        ACT_WRITE: ctl_d.state = ST_WR_REQ;
                        default:   ctl_d.state = ST_IDLE;
                    endcase
                end
            end
            ST_RD_REQ: begin
                if (mem_req_ready) begin
                    ctl_d.state = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    ctl_d.state    = ST_IDLE;
                    ctl_d.rd_we    = 1'b1;
                    ctl_d.done     = 1'b1;
                    ctl_d.rd_wdata = ctl_q.dword ? mem_rsp_rdata
                        : {{HALF_W{mem_rsp_rdata[HALF_W-1]}}, mem_rsp_rdata[HALF_W-1:0]};
                end
            end
            ST_WR_REQ: begin
                if (mem_req_ready) begin
                    ctl_d.state    = ST_IDLE;
                    ctl_d.rd_we    = 1'b1;
                    ctl_d.rd_wdata = '0;
                    ctl_d.done     = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_req_valid = (ctl_q.state == ST_RD_REQ) || (ctl_q.state == ST_WR_REQ);
    assign mem_req_write = (ctl_q.state == ST_WR_REQ);
    assign mem_req_dword = ctl_q.dword;
    assign mem_req_addr  = ctl_q.addr;
    assign mem_req_wdata = ctl_q.wdata;
    assign rd_we         = ctl_q.rd_we;
    assign rd_wdata      = ctl_q.rd_wdata;
    assign exc_valid     = ctl_q.exc_valid;
    assign exc_cause     = ctl_q.exc_cause;
    assign exc_tval      = ctl_q.exc_tval;
    assign done          = ctl_q.done;

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && exc_valid)); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)
         && $stable(mem_req_write))); // R12

    AST_FAIL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_act == ACT_FAIL) |=>
        (!mem_req_valid && rd_we && rd_wdata == DATA_W'(1))); // R7

    AST_EXC_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_act == ACT_EXC) |=> (exc_valid && !mem_req_valid)); // R3

    AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && !mem_req_dword) |->
        (mem_req_wdata[DATA_W-1:HALF_W] == '0)); // R9

endmodule

// File: tb/lrsc_unit_test.sv
module lrsc_unit_test;

    localparam logic [63:0] BASE   = 64'h0000_0000_8000_0000;
    localparam int          RBYTES = 4096;
    localparam int          GBYTES = 64;
    localparam int          NWORDS = RBYTES / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_funct5 = '0;
    logic [2:0]  op_funct3 = '0;
    logic [4:0]  op_rs2_idx = '0;
    logic [63:0] op_addr = '0;
    logic [63:0] op_wdata = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic        mem_req_dword;
    logic [63:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        snoop_valid = 1'b0;
    logic [63:0] snoop_addr = '0;
    logic        rd_we;
    logic [63:0] rd_wdata;
    logic        exc_valid;
    logic [3:0]  exc_cause;
    logic [63:0] exc_tval;
    logic        done;

    lrsc_unit #(.RAM_BASE(BASE), .RAM_BYTES(RBYTES), .GRAN_BYTES(GBYTES)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_funct5(op_funct5),
        .op_funct3(op_funct3), .op_rs2_idx(op_rs2_idx), .op_addr(op_addr),
        .op_wdata(op_wdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_dword(mem_req_dword),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .rd_we(rd_we),
        .rd_wdata(rd_wdata), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .exc_tval(exc_tval), .done(done)
    );

    always #5 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] mem_w [NWORDS];
    bit          m_valid = 1'b0;
    logic [63:0] m_tag = '0;
    string       m_why = "R7";

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit in_ram(input logic [63:0] a);
        return (a >= BASE) && ((a - BASE) < 64'(RBYTES));
    endfunction

    function automatic logic [63:0] gran(input logic [63:0] a);
        return (a - BASE) / 64'(GBYTES);
    endfunction

    function automatic logic [63:0] read_val(input logic [63:0] a, input bit dw);
        int i;
        i = int'((a - BASE) >> 2);
        return dw ? {mem_w[i+1], mem_w[i]} : {32'hA5A5_5A5A, mem_w[i]};
    endfunction

    task automatic do_op(input logic [4:0] f5, input logic [2:0] f3, input logic [4:0] r2,
                         input logic [63:0] a, input logic [63:0] wd,
                         input bit snp, input logic [63:0] sa);
        int          kind;      // 0 exc, 1 read, 2 fail, 3 write
        logic [3:0]  ecause;
        logic [63:0] etval;
        logic [63:0] erd;
        string       tag;
        bit          legal, dw, mis, hit_old, live, fin, saw, rsp_pend;
        int          rsp_wait;
        logic [63:0] xw;

        dw      = (f3 == 3'b011);
        legal   = ((f3 == 3'b010) || dw) &&
                  ((f5 == 5'b00010 && r2 == 0) || f5 == 5'b00011);
        mis     = dw ? (a[2:0] != 0) : (a[1:0] != 0);
        hit_old = snp && in_ram(sa) && m_valid && gran(sa) == m_tag;
        live    = m_valid && !hit_old;
        kind = 0; ecause = 4'd2; etval = '0; erd = '0;
        tag  = (f5 == 5'b00010 && r2 != 0) ? "R2" : "R1";
        xw   = dw ? wd : {32'h0, wd[31:0]};

        if (!legal) begin
            if (hit_old) begin m_valid = 0; m_why = "R10"; end
        end else if (f5 == 5'b00010) begin
            m_valid = 0; m_why = "R5";
            etval = a;
            if (mis) begin ecause = 4'd4; tag = "R3"; end
            else if (!in_ram(a)) begin ecause = 4'd5; tag = "R4"; end
            else begin
                kind = 1; tag = "R6"; erd = read_val(a, dw);
                if (!dw) erd = {{32{erd[31]}}, erd[31:0]};
                m_tag = gran(a);
                m_valid = !(snp && in_ram(sa) && gran(sa) == gran(a));
                if (!m_valid) m_why = "R10";
            end
        end else begin
            etval = a;
            if (!live) begin
                kind = 2; erd = 64'd1; tag = hit_old ? "R10" : m_why;
                m_valid = 0;
            end else if (mis) begin ecause = 4'd6; tag = "R3"; end
            else if (!in_ram(a)) begin ecause = 4'd7; tag = "R4"; end
            else if (gran(a) != m_tag) begin
                kind = 2; erd = 64'd1; tag = "R8"; m_valid = 0; m_why = "R8";
            end else begin
                kind = 3; erd = 64'd0; tag = "R9"; m_valid = 0; m_why = "R7";
            end
        end

        @(negedge clk);
        op_valid = 1; op_funct5 = f5; op_funct3 = f3; op_rs2_idx = r2;
        op_addr = a; op_wdata = wd; snoop_valid = snp; snoop_addr = sa;
        @(posedge clk);
        fin = 0; saw = 0; rsp_pend = 0; rsp_wait = 0;
        for (int cyc = 0; cyc < 60; cyc++) begin
            @(negedge clk);
            op_valid = 0; snoop_valid = 0; mem_req_ready = 0; mem_rsp_valid = 0;
            if (done || exc_valid) begin fin = 1; break; end
            if (mem_req_valid) begin
                if (kind < 1) chk({tag, " no memory request"}, 64'(mem_req_valid), 64'd0);
                else if (kind == 2) chk({tag, " no memory request"}, 64'(mem_req_valid), 64'd0);
                mem_req_ready = ($urandom % 3) != 0;
            end
            if (rsp_pend) begin
                if (rsp_wait == 0) begin
                    mem_rsp_valid = 1; mem_rsp_rdata = read_val(a, dw);
                end else rsp_wait--;
            end
            if (kind == 1 && ($urandom % 4) == 0) begin
                snoop_valid = 1;
                snoop_addr  = (($urandom % 2) == 0) ? (BASE + m_tag * GBYTES + 64'($urandom % 8) * 8)
                                                    : (BASE + 64'($urandom % 5) * GBYTES);
            end
            @(posedge clk);
            if (snoop_valid && in_ram(snoop_addr) && m_valid && gran(snoop_addr) == m_tag) begin
                m_valid = 0; m_why = "R10";
            end
            if (mem_req_valid && mem_req_ready && !saw) begin
                saw = 1;
                chk("R12 request address", mem_req_addr, a);
                chk("R12 request kind", {62'd0, mem_req_write, mem_req_dword}, {62'd0, kind == 3, dw});
                if (kind == 3) begin
                    chk("R9 write data", mem_req_wdata, xw);
                    mem_w[int'((a - BASE) >> 2)] = wd[31:0];
                    if (dw) mem_w[int'((a - BASE) >> 2) + 1] = wd[63:32];
                end else begin
                    rsp_pend = 1; rsp_wait = $urandom % 3;
                end
            end
            if (mem_rsp_valid) rsp_pend = 0;
        end
        if (!fin) begin
            chk({tag, " operation finished"}, 64'd0, 64'd1);
        end else if (kind == 0) begin
            chk({tag, " exception pulse"}, {63'd0, exc_valid}, 64'd1);
            chk({tag, " cause"}, 64'(exc_cause), 64'(ecause));
            chk({tag, " fault value"}, exc_tval, etval);
            chk("R11 no done with exception", {62'd0, done, rd_we}, 64'd0);
        end else begin
            chk("R11 done with rd write", {62'd0, done, rd_we}, 64'd3);
            chk({tag, " rd value"}, rd_wdata, erd);
            if (kind == 1 || kind == 3) chk({tag, " memory access made"}, 64'(saw), 64'd1);
        end
        @(negedge clk);
        chk("R11 single-cycle pulse", {61'd0, done, rd_we, exc_valid}, 64'd0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=finished");
        summary();
        $finish;
    end

    localparam logic [4:0]  LR = 5'b00010, SC = 5'b00011;
    localparam logic [2:0]  W = 3'b010, D = 3'b011;

    initial begin
        for (int i = 0; i < NWORDS; i++) mem_w[i] = 32'(i) * 32'h9E37_79B9 ^ 32'h1357_2468;
        mem_w[2] = 32'h8000_1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset pulses low", {61'd0, done, rd_we, exc_valid}, 64'd0);
        chk("R12 reset no request", 64'(mem_req_valid), 64'd0);
        rst_n = 1;

        do_op(SC, D, 0, BASE + 3, 64'h1, 0, 0);                 // R7 misaligned, no reservation
        do_op(LR, W, 0, BASE + 8, 0, 0, 0);                     // R6 negative word
        do_op(SC, W, 0, BASE + 12, 64'hFFFF_0000_CAFE_F00D, 0, 0); // R9 same granule
        do_op(SC, W, 0, BASE + 12, 64'h5, 0, 0);                // R7 consumed
        do_op(LR, D, 0, BASE + 64, 0, 0, 0);
        do_op(SC, D, 0, BASE + 128, 64'h77, 0, 0);              // R8 other granule
        do_op(LR, D, 0, BASE + 64, 0, 0, 0);
        do_op(SC, D, 0, BASE + 64, 64'h88, 1, BASE + 72);       // R10 same-cycle snoop
        do_op(LR, D, 0, BASE + 256, 0, 1, BASE + 300);          // R10 snoop on LR accept
        do_op(SC, D, 0, BASE + 256, 64'h99, 0, 0);
        do_op(LR, D, 5'd3, BASE + 64, 0, 0, 0);                 // R2
        do_op(LR, 3'b000, 0, BASE + 64, 0, 0, 0);               // R1
        do_op(LR, D, 0, BASE + 64, 0, 0, 0);
        do_op(LR, W, 0, BASE + 66, 0, 0, 0);                    // R3 then R5
        do_op(SC, W, 0, BASE + 64, 64'h1, 0, 0);
        do_op(LR, D, 0, BASE + 192, 0, 0, 0);
        do_op(SC, D, 0, BASE + 196, 64'h2, 0, 0);               // R3 keeps reservation
        do_op(SC, D, 0, BASE + RBYTES, 64'h3, 0, 0);            // R4 store fault
        do_op(SC, D, 0, BASE + 200, 64'h0123_4567_89AB_CDEF, 0, 0);
        do_op(LR, D, 0, BASE - 8, 0, 0, 0);                     // R4 load fault
        do_op(LR, D, 0, BASE + 200, 0, 0, 0);

        for (int n = 0; n < 400; n++) begin
            logic [4:0]  f5;
            logic [2:0]  f3;
            logic [4:0]  r2;
            logic [63:0] a;
            logic [63:0] sa;
            bit          snp;
            int          pick;
            f5 = (($urandom % 2) == 0) ? LR : SC;
            f3 = (($urandom % 2) == 0) ? W : D;
            r2 = (($urandom % 10) == 0) ? 5'(1 + $urandom % 31) : 5'd0;
            if (($urandom % 20) == 0) f3 = 3'($urandom % 8);
            if (($urandom % 25) == 0) f5 = 5'($urandom % 32);
            a = BASE + 64'($urandom % 4) * GBYTES + 64'($urandom % 8) * 8;
            if (f3 == W && ($urandom % 2) == 0) a = a + 4;
            pick = $urandom % 20;
            if (pick == 0) a = a + 64'(1 + $urandom % 3);
            else if (pick == 1) a = BASE - 64'(8 * (1 + $urandom % 4));
            else if (pick == 2) a = BASE + RBYTES + 64'(8 * ($urandom % 4));
            snp = ($urandom % 6) == 0;
            sa = (($urandom % 2) == 0) ? (BASE + m_tag * GBYTES + 64'($urandom % 8) * 8) : a;
            do_op(f5, f3, r2, a, {$urandom, $urandom}, snp, sa);
        end

        summary();
        $finish;
    end

endmodule